// File: doc/BRIEF.md
# Modulo-360 BCD Bearing Readout

This block keeps a three-digit decimal position count that advances by one on every display clock, from 000 upward, for a rotating pointer that completes one turn in 360 steps. The count does not wrap by itself. When it reaches the top value it holds there. It returns to 000 only when a separate coarse position counter wraps. That event is seen as a high-to-low transition on the `sync_in` line, which carries the top bit of the coarse counter.

`sync_in` is asynchronous. It passes through a flop synchroniser, and a falling-edge detector turns the transition into a one-cycle clear pulse. A clear always takes priority over a step.

A capture strobe takes a snapshot of all three live digits in a single edge. The snapshot is held until the next strobe. Each held digit is decoded into seven active-low segment lines. The outputs are static levels for a display, so they carry no handshake and there is no back-pressure.

Top module: `bearing_readout`

## Requirements
- R1: While `rst_n` is low, the live count and the held value are 000, and every digit shows the active-low pattern for zero (7'h40).
- R2: Away from a clear, the live count rises by one decimal step per clock edge. Each digit goes from 9 back to 0 and carries one into the next higher digit, so 009 becomes 010 and 099 becomes 100.
- R3: With no clear, the live count reaches 359 and then stays at 359. It never wraps to 000 by itself.
- R4: `sync_in` passes through two synchronising flops. Suppose `sync_in` is sampled low at clock edge n after being sampled high at edge n-1. Then the live count is 000 after edge n+2. This clear lasts exactly one cycle, and counting resumes from 000 at the next edge.
- R5: A rising transition of `sync_in`, or a steady level on it, never clears the count.
- R6: When a clear and a step fall in the same cycle, the clear wins and the count becomes 000.
- R7: At an edge where `capture` is high, `held_bcd` takes the live count as it stood before that edge, with all twelve bits taken together. While `capture` is low, `held_bcd` does not change. `held_bcd` holds hundreds in [11:8], tens in [7:4] and units in [3:0].
- R8: `seg_n` holds hundreds in [20:14], tens in [13:7] and units in [6:0]. Each digit is active low, with segment g at bit 6 and segment a at bit 0. Digits 0 to 9 give 40,79,24,30,19,12,02,78,00,10 in hex. Codes 10 to 15 blank the digit (7'h7F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock; one count step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous top bit of the coarse counter; its falling edge clears the count |
| capture | input | 1 | Snapshot strobe for the holding register |
| seg_n | output | 21 | Three active-low seven-segment digits (gfedcba each) |
| held_bcd | output | 12 | Held three-digit BCD snapshot |

## Verification
The bench walks the count through the carries at 009 and 099. It then runs past 359 to show that the count holds there. A design that wrapped, or that ran on to 360, would break the expected snapshot.

The bench places sync falls mid-count and at the held top value. It also uses a one-cycle low glitch, and a late or early clear would show up as an offset of one in the count. Rising edges and long steady levels of `sync_in` must leave the count alone; an edge detector of the wrong polarity would clear the count there.

With `capture` held low for long stretches, the snapshot must stay frozen. A register that sampled at every edge would move. Every held digit value is also checked against its segment pattern.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned DIG_W = 4;
  localparam int unsigned SEG_W = 7;
  typedef logic [DIG_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // active-low, bit 6 = g ... bit 0 = a; non-decimal codes blank
  function automatic seg_t bcd_to_seg_n(bcd_t d);
    seg_t on;
    case (d)
      4'd0: on = 7'b0111111;
      4'd1: on = 7'b0000110;
      4'd2: on = 7'b1011011;
      4'd3: on = 7'b1001111;
      4'd4: on = 7'b1100110;
      4'd5: on = 7'b1101101;
      4'd6: on = 7'b1111101;
      4'd7: on = 7'b0000111;
      4'd8: on = 7'b1111111;
      4'd9: on = 7'b1101111;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  // previous synchronised level high, current synchronised level low
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/bcd_sat_chain.sv
module bcd_sat_chain
  import brg_pkg::*;
#(
  parameter int unsigned DIGITS = 3,
  parameter int unsigned LIMIT  = 359
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  output logic [DIGITS*DIG_W-1:0] count
);
  localparam int unsigned W = DIGITS * DIG_W;

  logic [W-1:0]    lim_vec;
  logic [DIGITS:0] carry;
  logic            at_limit;

  assign at_limit = (count == lim_vec);
  assign carry[0] = ~at_limit;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dec
    localparam bcd_t LIM_D = bcd_t'((LIMIT / (10 ** i)) % 10);
    bcd_t d;
    assign lim_vec[i*DIG_W +: DIG_W] = LIM_D;
    assign count[i*DIG_W +: DIG_W]   = d;
    assign carry[i+1] = carry[i] & (d == 4'd9);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        d <= '0;
      else if (clr)      d <= '0;
      else if (carry[i]) d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
    end
  end
endmodule

// File: rtl/snap_reg.sv
module snap_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= d;
  end
endmodule

// File: rtl/seg_bank.sv
module seg_bank
  import brg_pkg::*;
#(
  parameter int unsigned DIGITS = 3
) (
  input  logic [DIGITS*DIG_W-1:0] bcd,
  output logic [DIGITS*SEG_W-1:0] seg_n
);
  for (genvar i = 0; i < DIGITS; i++) begin : g_seg
    assign seg_n[i*SEG_W +: SEG_W] = bcd_to_seg_n(bcd[i*DIG_W +: DIG_W]);
  end
endmodule

// File: rtl/bearing_readout.sv
module bearing_readout
  import brg_pkg::*;
#(
  parameter int unsigned DIGITS      = 3,
  parameter int unsigned LIMIT       = 359,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_in,
  input  logic                    capture,
  output logic [DIGITS*SEG_W-1:0] seg_n,
  output logic [DIGITS*DIG_W-1:0] held_bcd
);
  localparam int unsigned CW = DIGITS * DIG_W;

  logic          sync_fall;
  logic [CW-1:0] live_bcd;

  sync_fall_det #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sync_in), .fall(sync_fall)
  );

  bcd_sat_chain #(.DIGITS(DIGITS), .LIMIT(LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sync_fall), .count(live_bcd)
  );

  snap_reg #(.W(CW)) u_snap (
    .clk(clk), .rst_n(rst_n), .take(capture), .d(live_bcd), .q(held_bcd)
  );

  seg_bank #(.DIGITS(DIGITS)) u_seg (
    .bcd(held_bcd), .seg_n(seg_n)
  );
endmodule

// File: rtl/bearing_readout_chk.sv
module bearing_readout_chk #(
  parameter int unsigned CW  = 12,
  parameter logic [CW-1:0] TOP = 12'h359
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          capture,
  input logic [CW-1:0] count,
  input logic [CW-1:0] held
);
  p_hold_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !clr) |=> count == TOP);
  p_no_self_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !clr) |=> count != '0);
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  p_clear_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !clr);
  p_snapshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> held == $past(count));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held));
  p_decimal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count[3:0] <= 4'd9 && count[7:4] <= 4'd9 && count[11:8] <= 4'd9);
endmodule

bind bearing_readout bearing_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(sync_fall), .capture(capture),
  .count(live_bcd), .held(held_bcd)
);

// File: tb/sim_bearing_readout.sv
module sim_bearing_readout;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sync_in = 1;
  logic        capture = 0;
  logic [20:0] seg_n;
  logic [11:0] held_bcd;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  bearing_readout u0 (.clk(clk), .rst_n(rst_n), .sync_in(sync_in),
                      .capture(capture), .seg_n(seg_n), .held_bcd(held_bcd));

  always #2 clk = ~clk;  // 250 MHz

  // behavioural reference
  int m_live = 0, m_held = 0;
  bit s1 = 0, s2 = 0, s3 = 0;

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [6:0] pat(int d);
    logic [6:0] lit [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                             7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return ~lit[d];
  endfunction

  function automatic logic [20:0] segs(int v);
    return {pat(v / 100), pat((v / 10) % 10), pat(v % 10)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = 0; m_held = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      if (capture) m_held = m_live;
      if (s3 && !s2) m_live = 0;
      else if (m_live < 359) m_live = m_live + 1;
      s3 = s2; s2 = s1; s1 = sync_in;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check({tag, " R7 held"}, 32'(held_bcd), 32'(to_bcd(m_held)));
      check({tag, " R8 seg"}, 32'(seg_n), 32'(segs(m_held)));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1;
    check("R1 reset held", 32'(held_bcd), 32'h0);
    check("R1 reset seg", 32'(seg_n), 32'(21'h10_2040));
    run(3);
    rst_n = 1;
    // R2: carries through 009 and 099
    tag = "R2"; capture = 1;
    run(130);
    // R3: run beyond the top value
    tag = "R3";
    run(300);
    check("R3 holds at top", 32'(held_bcd), 32'h359);
    // R4: fall while at top
    tag = "R4";
    sync_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 zero after fall", 32'(held_bcd), 32'h000);
    run(20);
    // R5: rising edge and long steady levels
    tag = "R5";
    sync_in = 1;
    run(40);
    check("R5 no clear on rise", 32'(held_bcd), 32'(to_bcd(m_held)));
    // R6: clear mid-count, plus one-cycle glitch
    tag = "R6";
    sync_in = 0; run(25);
    sync_in = 1; run(60);
    sync_in = 0; run(1); sync_in = 1;
    run(10);
    // R7: snapshot frozen, then sparse strobes
    tag = "R7";
    capture = 0;
    run(50);
    for (int k = 0; k < 40; k++) begin
      capture = (k % 7 == 3);
      run(3);
    end
    capture = 1;
    run(400);
    // R1: reset mid-run
    tag = "R1";
    rst_n = 0; #1;
    check("R1 async reset held", 32'(held_bcd), 32'h0);
    run(2);
    rst_n = 1; tag = "R8";
    run(380);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule